// File: doc/BRIEF.md
# Stream-ID Routed Packet Switch

This block is a four-in, four-out packet switch for valid/ready streams with a last-word marker. Each packet opens with a 32-bit header word that carries a stream identifier. The switch reads the destination network and destination host fields of that word and uses them to pick the egress port. It then carries the whole packet to that port and only releases the port after the word marked last.

Routing is a two-level lookup, loaded through a small write-only settings port. The first level compares the destination network with a programmable local network address. If they are equal, a host table indexed by the destination host selects the port. If they differ, a network table indexed by the destination network selects it. The switch does not check that the tables are consistent; it routes on whatever they hold.

Each egress port has its own round-robin arbiter. The arbiter holds its grant for a whole packet, so packets from different inputs never interleave on one output. An input that loses arbitration sees ready held low. Inputs aimed at other, free outputs move in the same cycle.

Top module: `sps_switch`

## Requirements
- R1: After reset both tables and the local address are zero, every `out_valid` is low, and any packet is delivered on egress port 0.
- R2: A settings write to address 512 loads `set_data[7:0]` as the local network address.
- R3: The destination network is header bits [15:8]. A settings write to an address A in 0..255 stores `set_data[1:0]` as the egress port for destination network A. That entry is used whenever the destination network differs from the local address.
- R4: The destination host is header bits [7:0]. A settings write to an address A in 256..511 stores `set_data[1:0]` as the egress port for destination host A-256. That entry is used only when the destination network equals the local address.
- R5: Settings writes to addresses 513..1023 change no table entry and not the local address.
- R6: The egress port is chosen from the first word of a packet and is kept until the last word is transferred. Once an egress port has granted an input, it carries only that input's words until that packet's last word.
- R7: When several inputs contend for one egress port, the arbiter grants them in round-robin order starting after the input that finished most recently. With three inputs always requesting, any three packets in a row come from three different inputs.
- R8: Packets aimed at different egress ports move in the same cycle, each without waiting for the other.
- R9: An input is ready only while it holds the grant of its target egress port and that port's `out_ready` is high. A losing or stalled input sees `in_ready` low, and the granted word stays presented on the output.
- R10: On each egress port, the packets from any one input leave in the order that input sent them, and their words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 10 | Settings write address |
| set_data | input | 8 | Settings write data |
| in_valid | input | 4 | Per-input word valid |
| in_last | input | 4 | Per-input last-word marker |
| in_data | input | 128 | Per-input 32-bit words, input i at bits [32i+31:32i] |
| in_ready | output | 4 | Per-input ready |
| out_valid | output | 4 | Per-output word valid |
| out_last | output | 4 | Per-output last-word marker |
| out_data | output | 128 | Per-output 32-bit words, output e at bits [32e+31:32e] |
| out_ready | input | 4 | Per-output ready from the sink |

## Verification
The bench targets the points where the two lookup levels meet. It uses a destination that hits the local address but finds an empty host entry, and a network entry that differs from the host entry at the same index, so a design with swapped tables or a missing local compare delivers on the wrong port. It writes to an address above 512 whose low nine bits alias a host entry, which exposes a truncated address decode. It has three inputs of different packet lengths contend for one output while that output's ready toggles. A fixed-priority arbiter then gives a repeated source, a grant dropped mid-packet gives words from mixed packets, and a route that is re-read from payload words sends data to the wrong port. It stalls an output to check that every contender's ready stays low while the head word is held steady.

// File: rtl/sps_pkg.sv
// Shared constants for the stream-ID switch: header field positions and
// settings address map. Assumes 8-bit address fields in the stream ID.
package sps_pkg;
    localparam int FIELD_W      = 8;
    localparam int DST_NET_LSB  = 8;
    localparam int DST_HOST_LSB = 0;
    localparam int HDR_USED_W   = 2 * FIELD_W;
    localparam int TBL_ENTRIES  = 1 << FIELD_W;
    localparam int SET_AW       = 10;
    localparam int SET_DW       = FIELD_W;
    localparam int HOST_BASE    = TBL_ENTRIES;
    localparam int LOCAL_ADDR   = 2 * TBL_ENTRIES;
endpackage

// File: rtl/sps_route_table.sv
// Route table: holds the local network address plus the network and host
// lookup tables, and resolves an egress port for each input header.
// Assumes headers are the low 16 bits of each input's first word.
module sps_route_table
    import sps_pkg::*;
#(
    parameter int NP = 4,
    localparam int PW = $clog2(NP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_stb,
    input  logic [SET_AW-1:0]      set_addr,
    input  logic [SET_DW-1:0]      set_data,
    input  logic [NP*HDR_USED_W-1:0] hdr,
    output logic [NP*PW-1:0]       port_sel
);
    logic [PW-1:0]      net_tbl  [TBL_ENTRIES];
    logic [PW-1:0]      host_tbl [TBL_ENTRIES];
    logic [FIELD_W-1:0] local_q;

    logic net_wr, host_wr, local_wr;
    assign net_wr   = set_stb && (set_addr <  SET_AW'(HOST_BASE));
    assign host_wr  = set_stb && (set_addr >= SET_AW'(HOST_BASE)) && (set_addr < SET_AW'(LOCAL_ADDR));
    assign local_wr = set_stb && (set_addr == SET_AW'(LOCAL_ADDR));

    // Load or clear the routing configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_q <= '0;
            for (int k = 0; k < TBL_ENTRIES; k++) begin
                net_tbl[k]  <= '0;
                host_tbl[k] <= '0;
            end
        end else begin
            if (local_wr) local_q <= set_data;
            if (net_wr)   net_tbl[set_addr[FIELD_W-1:0]]  <= set_data[PW-1:0];
            if (host_wr)  host_tbl[set_addr[FIELD_W-1:0]] <= set_data[PW-1:0];
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_look
        logic [FIELD_W-1:0] dst_net, dst_host;
        assign dst_net  = hdr[i*HDR_USED_W + DST_NET_LSB  +: FIELD_W];
        assign dst_host = hdr[i*HDR_USED_W + DST_HOST_LSB +: FIELD_W];
        // Two-level lookup: local network uses host table, else network table.
        assign port_sel[i*PW +: PW] = (dst_net == local_q) ? host_tbl[dst_host] : net_tbl[dst_net];
    end

    assert_local_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(local_wr) |-> local_q == $past(set_data));
    assert_net_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(net_wr) |-> net_tbl[$past(set_addr[FIELD_W-1:0])] == $past(set_data[PW-1:0]));
endmodule

// File: rtl/sps_ingress_ctl.sv
// Ingress tracker: latches the route at a packet's first accepted word and
// keeps it until the last word; turns it into a one-hot egress request.
// Assumes the upstream source keeps valid and data steady until ready.
module sps_ingress_ctl #(
    parameter int NP = 4,
    localparam int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          in_ready,
    input  logic [PW-1:0] fresh_sel,
    output logic [PW-1:0] route_sel,
    output logic [NP-1:0] req
);
    logic          busy_q;
    logic [PW-1:0] route_q;
    logic          accept;

    assign accept    = in_valid && in_ready;
    assign route_sel = busy_q ? route_q : fresh_sel;

    // Request only the selected egress while a word is offered.
    always_comb begin
        req = '0;
        if (in_valid) req[route_sel] = 1'b1;
    end

    // Track packet boundaries and hold the route chosen by the header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            route_q <= '0;
        end else if (accept) begin
            if (!busy_q) route_q <= fresh_sel;
            busy_q <= !in_last;
        end
    end

    assert_route_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_last) |=> route_sel == $past(route_sel));
endmodule

// File: rtl/sps_egress_arb.sv
// Egress arbiter: round-robin among requesting inputs, grant locked from
// the first transferred word to the last. Assumes NP is a power of two.
module sps_egress_arb #(
    parameter int NP = 4,
    localparam int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    input  logic          xfer,
    input  logic          xfer_last,
    output logic [NP-1:0] grant
);
    logic          lock_q;
    logic [NP-1:0] own_q;
    logic [PW-1:0] ptr_q;
    logic [NP-1:0] pick;
    logic [PW-1:0] own_idx;

    // Pick the first requester at or after the round-robin pointer.
    always_comb begin
        int  idx;
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NP; k++) begin
            idx = (int'(ptr_q) + k) % NP;
            if (!found && req[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    assign grant = lock_q ? own_q : pick;

    // Encode the current owner's index.
    always_comb begin
        own_idx = '0;
        for (int k = 0; k < NP; k++)
            if (grant[k]) own_idx = PW'(k);
    end

    // Lock on a mid-packet transfer; release and advance pointer on last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            own_q  <= '0;
            ptr_q  <= '0;
        end else if (xfer) begin
            if (xfer_last) begin
                lock_q <= 1'b0;
                ptr_q  <= PW'((int'(own_idx) + 1) % NP);
            end else begin
                lock_q <= 1'b1;
                own_q  <= grant;
            end
        end
    end

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !xfer_last) |=> grant == $past(grant));
endmodule

// File: rtl/sps_switch.sv
// Stream-ID packet switch top: route table, one ingress tracker per input,
// one arbiter per output, and the data crossbar between them.
// Assumes valid/ready sources that hold data steady until accepted.
module sps_switch
    import sps_pkg::*;
#(
    parameter int NP = 4,
    parameter int DW = 32,
    localparam int PW = $clog2(NP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic [SET_AW-1:0] set_addr,
    input  logic [SET_DW-1:0] set_data,
    input  logic [NP-1:0]     in_valid,
    input  logic [NP-1:0]     in_last,
    input  logic [NP*DW-1:0]  in_data,
    output logic [NP-1:0]     in_ready,
    output logic [NP-1:0]     out_valid,
    output logic [NP-1:0]     out_last,
    output logic [NP*DW-1:0]  out_data,
    input  logic [NP-1:0]     out_ready
);
    logic [NP*HDR_USED_W-1:0] hdr;
    logic [NP*PW-1:0]         fresh_sel;
    logic [PW-1:0]            route_sel [NP];
    logic [NP-1:0]            ing_req   [NP];
    logic [NP-1:0]            egr_req   [NP];
    logic [NP-1:0]            egr_grant [NP];
    logic [NP-1:0]            xfer, xfer_last;

    for (genvar i = 0; i < NP; i++) begin : g_hdr
        assign hdr[i*HDR_USED_W +: HDR_USED_W] = in_data[i*DW +: HDR_USED_W];
    end

    sps_route_table #(.NP(NP)) u_tbl (
        .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_addr(set_addr),
        .set_data(set_data), .hdr(hdr), .port_sel(fresh_sel)
    );

    for (genvar i = 0; i < NP; i++) begin : g_ing
        sps_ingress_ctl #(.NP(NP)) u_ing (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid[i]), .in_last(in_last[i]),
            .in_ready(in_ready[i]), .fresh_sel(fresh_sel[i*PW +: PW]),
            .route_sel(route_sel[i]), .req(ing_req[i])
        );
    end

    for (genvar e = 0; e < NP; e++) begin : g_egr
        sps_egress_arb #(.NP(NP)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(egr_req[e]), .xfer(xfer[e]),
            .xfer_last(xfer_last[e]), .grant(egr_grant[e])
        );
    end

    // Crossbar: transpose requests, mux granted words out, return ready.
    always_comb begin
        out_valid = '0;
        out_last  = '0;
        out_data  = '0;
        in_ready  = '0;
        for (int e = 0; e < NP; e++) begin
            for (int i = 0; i < NP; i++) begin
                egr_req[e][i] = ing_req[i][e];
                if (egr_grant[e][i]) begin
                    out_valid[e]         = out_valid[e] | in_valid[i];
                    out_last[e]          = out_last[e]  | in_last[i];
                    out_data[e*DW +: DW] = out_data[e*DW +: DW] | in_data[i*DW +: DW];
                    in_ready[i]          = in_ready[i]  | out_ready[e];
                end
            end
            xfer[e]      = out_valid[e] && out_ready[e];
            xfer_last[e] = xfer[e] && out_last[e];
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_chk
        assert_ready_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_ready[i] && in_valid[i]) |-> out_ready[route_sel[i]]);
    end
endmodule

// File: tb/sim_sps_switch.sv
// Directed bench for the stream-ID packet switch.
module sim_sps_switch;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         set_stb = 0;
    logic [9:0]   set_addr = 0;
    logic [7:0]   set_data = 0;
    logic [3:0]   in_valid = 0, in_last = 0, out_ready = 4'hF;
    logic [127:0] in_data = 0;
    logic [3:0]   in_ready, out_valid, out_last;
    logic [127:0] out_data;

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] rec_data [4][64];
    logic        rec_last [4][64];
    int          rec_time [4][64];
    int          rec_cnt  [4];

    sps_switch u0 (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor: log words that will transfer at the next edge.
    always @(negedge clk) begin
        #3;
        for (int e = 0; e < 4; e++)
            if (out_valid[e] && out_ready[e] && rec_cnt[e] < 64) begin
                rec_data[e][rec_cnt[e]] = out_data[e*32 +: 32];
                rec_last[e][rec_cnt[e]] = out_last[e];
                rec_time[e][rec_cnt[e]] = cyc;
                rec_cnt[e]++;
            end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int e = 0; e < 4; e++) rec_cnt[e] = 0;
    endtask

    task automatic set_wr(int a, int d);
        @(negedge clk);
        set_stb = 1; set_addr = 10'(a); set_data = 8'(d);
        @(negedge clk);
        set_stb = 0;
    endtask

    function automatic logic [31:0] mk_hdr(int id, int src, int dn, int dh);
        return {8'(id), 8'(src), 8'(dn), 8'(dh)};
    endfunction

    task automatic send_pkt(int i, logic [31:0] hdr, int len);
        for (int w = 0; w < len; w++) begin
            @(negedge clk);
            in_valid[i] = 1;
            in_data[i*32 +: 32] = (w == 0) ? hdr : {4'hD, 4'(i), hdr[31:24], 16'(w)};
            in_last[i] = (w == len - 1);
            #1;
            while (!in_ready[i]) begin
                @(negedge clk); #1;
            end
        end
    endtask

    task automatic idle(int i);
        @(negedge clk);
        in_valid[i] = 0; in_last[i] = 0;
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    // Send one packet from input 0 and check which port received it.
    task automatic route_case(string tag, int dn, int dh, int exp_port);
        clear_log();
        send_pkt(0, mk_hdr(1, 0, dn, dh), 2);
        idle(0);
        drain();
        chk(tag, rec_cnt[exp_port], 2);
        chk(tag, rec_cnt[0] + rec_cnt[1] + rec_cnt[2] + rec_cnt[3], 2);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 out_valid after reset", out_valid, 0);
        route_case("R1 zero tables route to port0", 5, 3, 0);
    endtask

    task automatic t_config();
        set_wr(512, 2);
        set_wr(7, 3);
        set_wr(9, 1);
        set_wr(2, 1);
        set_wr(256 + 1, 2);
        set_wr(256 + 3, 3);
        route_case("R3 net 7 to port3", 7, 0, 3);
        route_case("R3 net 9 host 1 uses net table", 9, 1, 1);
        route_case("R4 local net host 1 to port2", 2, 1, 2);
        route_case("R4 local net host 0 empty entry", 2, 0, 0);
        route_case("R2 local net ignores net entry 2", 2, 3, 3);
    endtask

    task automatic t_ignored();
        set_wr(768, 3);
        set_wr(513, 1);
        set_wr(1023, 2);
        route_case("R5 alias of host 0 untouched", 2, 0, 0);
        route_case("R5 local addr unchanged", 2, 1, 2);
        route_case("R5 net 1 untouched", 1, 0, 0);
    endtask

    task automatic t_parallel();
        clear_log();
        fork
            begin send_pkt(0, mk_hdr(2, 0, 7, 0), 3); idle(0); end
            begin send_pkt(1, mk_hdr(3, 1, 9, 0), 3); idle(1); end
        join
        drain();
        chk("R8 port3 words", rec_cnt[3], 3);
        chk("R8 port1 words", rec_cnt[1], 3);
        chk("R8 same start cycle", rec_time[3][0], rec_time[1][0]);
    endtask

    task automatic t_backpressure();
        clear_log();
        @(negedge clk); out_ready[1] = 0;
        fork
            begin send_pkt(3, mk_hdr(4, 3, 9, 0), 2); idle(3); end
            begin send_pkt(2, mk_hdr(5, 2, 9, 0), 2); idle(2); end
            begin
                repeat (3) @(negedge clk);
                #1;
                chk("R9 out_valid held under stall", out_valid[1], 1);
                chk("R9 stalled input3 not ready", in_ready[3], 0);
                chk("R9 stalled input2 not ready", in_ready[2], 0);
                chk("R9 head word held", out_data[63:32][15:0], 16'h0900);
                @(negedge clk); out_ready[1] = 1;
            end
        join
        drain();
        chk("R9 all words delivered after stall", rec_cnt[1], 4);
    endtask

    task automatic t_contend();
        int src [8];
        int np = 0, mix = 0, order = 0;
        int lastid [3] = '{-1, -1, -1};
        logic [31:0] h;
        clear_log();
        fork
            for (int i = 0; i < 3; i++) begin
                automatic int ii = i;
                fork
                    begin
                        send_pkt(ii, mk_hdr(ii*16, ii, 2, 1), 2 + ii);
                        send_pkt(ii, mk_hdr(ii*16 + 1, ii, 2, 1), 2 + ii);
                        idle(ii);
                    end
                join_none
            end
            begin
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk); out_ready[2] = (k % 3 != 0);
                end
                out_ready[2] = 1;
            end
        join
        wait fork;
        drain();
        chk("R10 word count on port2", rec_cnt[2], 18);
        h = 0;
        for (int w = 0; w < rec_cnt[2]; w++) begin
            logic [31:0] d = rec_data[2][w];
            if (w == 0 || rec_last[2][w-1]) begin
                h = d;
                if (np < 8) src[np] = int'(d[23:16]);
                np++;
                if (d[23:16] < 3) begin
                    if (int'(d[31:24]) <= lastid[d[23:16]]) order++;
                    lastid[d[23:16]] = int'(d[31:24]);
                end
            end else if (d[27:24] != h[19:16] || d[23:16] != h[31:24] || d[31:28] != 4'hD) begin
                mix++;
            end
        end
        chk("R6 no interleaved words", mix, 0);
        chk("R10 per-input order", order, 0);
        chk("R7 packet count", np, 6);
        if (np >= 6) begin
            chk("R7 first three distinct", (src[0] != src[1] && src[1] != src[2] && src[0] != src[2]), 1);
            chk("R7 next three distinct", (src[3] != src[4] && src[4] != src[5] && src[3] != src[5]), 1);
        end
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_log();
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_config();
        t_ignored();
        t_parallel();
        t_backpressure();
        t_contend();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule